// File: doc/BRIEF.md
# Dual Prefetch Queue Controller

This block sits between an instruction cache and an instruction decoder and keeps two byte buffers of fetched code, of which exactly one is active. Cache lines accepted on the line stream are appended to the active buffer, and the decoder drains the active buffer through a byte window of up to sixteen bytes per transfer. The block also drives the address of the next line to fetch.

When the front end predicts a branch taken, the controller parks the current buffer, with its fall-through bytes intact, and starts filling the other buffer from the branch target. If the branch later resolves as correctly predicted, the parked buffer is discarded and becomes free for the next predicted-taken branch. If it resolves as mispredicted, the controller pulses a flush, discards the target-path buffer, stalls the stream interfaces for a fixed recovery window, and then resumes decode from the parked buffer without refetching. The fetch address returns to the line that follows the last line accepted before the switch. A second predicted-taken branch that arrives while one is still unresolved is held, and fetch stalls until the first branch resolves.

Both data interfaces use valid/ready handshakes. A line is accepted on a rising edge where `line_valid` and `line_ready` are both high. `line_ready` falls whenever a line cannot be stored, and the cache must then hold its line until it is accepted. A decode transfer takes place on a rising edge where `dec_valid` and `dec_ready` are both high, and it removes all `dec_count` bytes presented in that cycle. The decoder may hold `dec_ready` low for as long as it needs.

Top module: `dpq_ctrl`

## Requirements
- R1: After reset, both buffers are empty and buffer 0 is active. `dec_valid` and `flush` are low, `line_ready` is high, and `fetch_addr` equals the RESET_ADDR parameter (default 0x1000).
- R2: An accepted line appends its 32 bytes to the active buffer in byte order, with byte 0 in `line_data[7:0]`. On the next cycle `fetch_addr` has advanced by 32.
- R3: Each buffer holds 64 bytes. `line_ready` is low whenever the active buffer has fewer than 32 free bytes, so no buffer ever holds more than 64.
- R4: `dec_valid` is high when the active buffer is non-empty and the block is not recovering. `dec_count` is the smaller of the stored byte count and 16. Byte i of `dec_data` (bits 8i+7..8i) is the i-th oldest stored byte, and a decode transfer removes `dec_count` bytes.
- R5: A `pred_valid` pulse with no branch outstanding and no recovery in progress makes the other, empty buffer active on the next cycle and sets `fetch_addr` to `pred_target`. The bytes left in the previously active buffer stay untouched.
- R6: A `res_valid` pulse with `res_mispredict` low while a branch is outstanding keeps the active buffer, empties the parked buffer, and raises no flush.
- R7: A `res_valid` pulse with `res_mispredict` high while a branch is outstanding raises `flush` for exactly the next cycle. It also empties the target-path buffer, reactivates the parked buffer, and restores `fetch_addr` to the line after the last one accepted before the switch.
- R8: After a mispredict, `dec_valid` and `line_ready` stay low for 3 cycles (the STALL_CYC parameter), and `flush` is high in the first of them. Decode then resumes with the oldest remaining byte of the parked buffer.
- R9: A `pred_valid` pulse while a branch is outstanding holds its target and keeps `line_ready` low until resolution. On a correct resolution the controller switches at once to the held target, on the buffer just freed. On a mispredict the held target is dropped.
- R10: `res_valid` with no branch outstanding has no effect on `flush`, `fetch_addr` or the buffers, and `pred_valid` during the recovery window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | Cache line offered |
| line_ready | output | 1 | Line can be accepted this cycle |
| line_data | input | 256 | Cache line, byte 0 in bits 7..0 |
| fetch_addr | output | 32 | Address of the next line to fetch |
| pred_valid | input | 1 | Pulse: branch predicted taken |
| pred_target | input | 32 | Target address of the predicted branch |
| res_valid | input | 1 | Pulse: outstanding branch resolved |
| res_mispredict | input | 1 | With res_valid: prediction was wrong |
| dec_valid | output | 1 | Decode window holds bytes |
| dec_ready | input | 1 | Decoder takes the whole window |
| dec_count | output | 5 | Number of valid bytes in the window |
| dec_data | output | 128 | Decode window, oldest byte in bits 7..0 |
| flush | output | 1 | One-cycle pipeline flush on a mispredict |

## Verification
A wrong choice of active buffer shows on the decode window on the very next cycle, as bytes from the wrong path or an unexpected empty window. That is why every switch is followed by a check of byte 0 against the bytes the bench fed on that path. A parked buffer that was not emptied, or a held target that was not dropped, stays hidden until the next switch or recovery brings that buffer forward. The scenarios therefore force such a switch and then read the window and `fetch_addr`. Pointer and count errors surface as shifted bytes within one transfer, or as `line_ready` at the wrong fill level.

// File: rtl/dpq_pkg.sv
package dpq_pkg;
  // Controller phase: normal fetch, one branch outstanding, or mispredict recovery.
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SPEC    = 2'd1,
    ST_RECOVER = 2'd2
  } dpq_state_e;
endpackage

// File: rtl/dpq_buf.sv
// One byte ring buffer: whole-line writes, window reads, synchronous clear.
// DEPTH and WR_BYTES must be powers of two with WR_BYTES < DEPTH.
module dpq_buf #(
  parameter int DEPTH    = 64,
  parameter int WR_BYTES = 32,
  parameter int RD_BYTES = 16,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = PW + 1,
  localparam int LW      = $clog2(WR_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [WR_BYTES*8-1:0] wr_data,
  input  logic                  rd_en,
  input  logic [CW-1:0]         rd_take,
  output logic [RD_BYTES*8-1:0] rd_data,
  output logic [CW-1:0]         count,
  output logic                  has_room
);
  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] off_w [DEPTH];

  // Offset of every slot from the write pointer; slots inside the line get written.
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      off_w[j] = PW'(j) - wr_q;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      if (wr_en && !clr && (off_w[j][PW-1:LW] == '0)) begin
        mem_q[j] <= wr_data[{off_w[j][LW-1:0], 3'b000} +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= wr_q + PW'(WR_BYTES);
      if (rd_en) rd_q <= rd_q + rd_take[PW-1:0];
      cnt_q <= cnt_q + (wr_en ? CW'(WR_BYTES) : '0) - (rd_en ? rd_take : '0);
    end
  end

  for (genvar i = 0; i < RD_BYTES; i++) begin : g_win
    assign rd_data[8*i +: 8] = mem_q[rd_q + PW'(i)];
  end

  assign count    = cnt_q;
  assign has_room = (CW'(DEPTH) - cnt_q) >= CW'(WR_BYTES);
endmodule

// File: rtl/dpq_sel.sv
// Buffer selection, branch bookkeeping, fetch address and recovery timing.
module dpq_sel
  import dpq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          LINE_BYTES = 32,
  parameter int          STALL_CYC  = 3,
  parameter logic [31:0] RESET_ADDR = 32'h0000_1000,
  localparam int         RW         = $clog2(STALL_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pred_valid,
  input  logic [AW-1:0] pred_target,
  input  logic          res_valid,
  input  logic          res_mispredict,
  input  logic          line_fire,
  output logic          act,
  output logic [1:0]    clr,
  output logic          spec,
  output logic          hold,
  output logic          stall,
  output logic          flush,
  output logic [AW-1:0] fetch_addr
);
  dpq_state_e    st_q, st_n;
  logic          act_q, act_n;
  logic          hold_q, hold_n;
  logic          flush_q, flush_n;
  logic [AW-1:0] fa_q, fa_n, fa_adv;
  logic [AW-1:0] save_q, save_n;
  logic [AW-1:0] held_q, held_n;
  logic [RW-1:0] rec_q, rec_n;
  logic          pred_ok;

  assign fa_adv  = fa_q + (line_fire ? AW'(LINE_BYTES) : '0);
  assign pred_ok = pred_valid && (st_q != ST_RECOVER);

  always_comb begin
    st_n    = st_q;
    act_n   = act_q;
    hold_n  = hold_q;
    held_n  = held_q;
    save_n  = save_q;
    fa_n    = fa_adv;
    rec_n   = rec_q;
    flush_n = 1'b0;
    clr     = 2'b00;
    unique case (st_q)
      ST_RUN: begin
        if (pred_ok) begin
          st_n   = ST_SPEC;
          act_n  = ~act_q;
          save_n = fa_adv;
          fa_n   = pred_target;
        end
      end
      ST_SPEC: begin
        if (res_valid && res_mispredict) begin
          clr     = act_q ? 2'b10 : 2'b01;
          act_n   = ~act_q;
          fa_n    = save_q;
          hold_n  = 1'b0;
          flush_n = 1'b1;
          rec_n   = RW'(STALL_CYC - 1);
          st_n    = ST_RECOVER;
        end else if (res_valid) begin
          clr    = act_q ? 2'b01 : 2'b10;
          hold_n = 1'b0;
          if (hold_q || pred_ok) begin
            act_n  = ~act_q;
            save_n = fa_adv;
            fa_n   = hold_q ? held_q : pred_target;
          end else begin
            st_n = ST_RUN;
          end
        end else if (pred_ok && !hold_q) begin
          hold_n = 1'b1;
          held_n = pred_target;
        end
      end
      ST_RECOVER: begin
        if (rec_q == '0) st_n = ST_RUN;
        else             rec_n = rec_q - RW'(1);
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      act_q   <= 1'b0;
      hold_q  <= 1'b0;
      held_q  <= '0;
      save_q  <= '0;
      fa_q    <= AW'(RESET_ADDR);
      rec_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      act_q   <= act_n;
      hold_q  <= hold_n;
      held_q  <= held_n;
      save_q  <= save_n;
      fa_q    <= fa_n;
      rec_q   <= rec_n;
      flush_q <= flush_n;
    end
  end

  assign act        = act_q;
  assign spec       = (st_q == ST_SPEC);
  assign hold       = hold_q;
  assign stall      = (st_q == ST_RECOVER);
  assign flush      = flush_q;
  assign fetch_addr = fa_q;
endmodule

// File: rtl/dpq_ctrl.sv
// Top: two prefetch buffers, the selector, and the stream muxing.
module dpq_ctrl #(
  parameter int          AW         = 32,
  parameter int          BUF_BYTES  = 64,
  parameter int          LINE_BYTES = 32,
  parameter int          OUT_BYTES  = 16,
  parameter int          STALL_CYC  = 3,
  parameter logic [31:0] RESET_ADDR = 32'h0000_1000,
  localparam int         CW         = $clog2(BUF_BYTES) + 1,
  localparam int         OCW        = $clog2(OUT_BYTES) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_valid,
  output logic                    line_ready,
  input  logic [LINE_BYTES*8-1:0] line_data,
  output logic [AW-1:0]           fetch_addr,
  input  logic                    pred_valid,
  input  logic [AW-1:0]           pred_target,
  input  logic                    res_valid,
  input  logic                    res_mispredict,
  output logic                    dec_valid,
  input  logic                    dec_ready,
  output logic [OCW-1:0]          dec_count,
  output logic [OUT_BYTES*8-1:0]  dec_data,
  output logic                    flush
);
  logic                   act, spec, hold, stall;
  logic [1:0]             clr;
  logic [1:0]             room;
  logic [CW-1:0]          buf_cnt [2];
  logic [OUT_BYTES*8-1:0] win [2];
  logic                   line_fire, dec_fire;
  logic [CW-1:0]          act_cnt;

  dpq_sel #(
    .AW(AW), .LINE_BYTES(LINE_BYTES), .STALL_CYC(STALL_CYC), .RESET_ADDR(RESET_ADDR)
  ) u_sel (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_target(pred_target),
    .res_valid(res_valid), .res_mispredict(res_mispredict),
    .line_fire(line_fire),
    .act(act), .clr(clr), .spec(spec), .hold(hold), .stall(stall),
    .flush(flush), .fetch_addr(fetch_addr)
  );

  for (genvar k = 0; k < 2; k++) begin : g_buf
    dpq_buf #(
      .DEPTH(BUF_BYTES), .WR_BYTES(LINE_BYTES), .RD_BYTES(OUT_BYTES)
    ) u_buf (
      .clk(clk), .rst_n(rst_n),
      .clr(clr[k]),
      .wr_en(line_fire && (act == 1'(k))),
      .wr_data(line_data),
      .rd_en(dec_fire && (act == 1'(k))),
      .rd_take(CW'(dec_count)),
      .rd_data(win[k]),
      .count(buf_cnt[k]),
      .has_room(room[k])
    );
  end

  assign act_cnt    = buf_cnt[act];
  assign line_ready = room[act] && !hold && !stall;
  assign line_fire  = line_valid && line_ready;
  assign dec_valid  = (act_cnt != '0) && !stall;
  assign dec_count  = (act_cnt > CW'(OUT_BYTES)) ? OCW'(OUT_BYTES) : OCW'(act_cnt);
  assign dec_data   = win[act];
  assign dec_fire   = dec_valid && dec_ready;
endmodule

// File: rtl/dpq_ctrl_chk.sv
// Property checker, attached to every dpq_ctrl instance.
module dpq_ctrl_chk #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 64,
  parameter int OUT_BYTES = 16,
  localparam int CW       = $clog2(BUF_BYTES) + 1,
  localparam int OCW      = $clog2(OUT_BYTES) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush,
  input logic           dec_valid,
  input logic [OCW-1:0] dec_count,
  input logic           line_ready,
  input logic           res_valid,
  input logic           res_mispredict,
  input logic           pred_valid,
  input logic [AW-1:0]  pred_target,
  input logic [AW-1:0]  fetch_addr,
  input logic           spec,
  input logic           hold,
  input logic           stall,
  input logic [CW-1:0]  cnt0,
  input logic [CW-1:0]  cnt1
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 <= CW'(BUF_BYTES)) && (cnt1 <= CW'(BUF_BYTES)));

  p_dec_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_count != '0) && (dec_count <= OCW'(OUT_BYTES)));

  p_switch_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !spec && !stall) |=> (fetch_addr == $past(pred_target)));

  p_correct_noflush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_mispredict) |=> !flush);

  p_mispredict_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict && spec) |=> flush);

  p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  p_recover_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!dec_valid && !line_ready));

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !line_ready);

  p_idle_resolve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !spec) |=> !flush);
endmodule

bind dpq_ctrl dpq_ctrl_chk #(
  .AW(AW), .BUF_BYTES(BUF_BYTES), .OUT_BYTES(OUT_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .dec_valid(dec_valid), .dec_count(dec_count), .line_ready(line_ready),
  .res_valid(res_valid), .res_mispredict(res_mispredict),
  .pred_valid(pred_valid), .pred_target(pred_target), .fetch_addr(fetch_addr),
  .spec(spec), .hold(hold), .stall(stall),
  .cnt0(buf_cnt[0]), .cnt1(buf_cnt[1])
);

// File: tb/dpq_ctrl_tb.sv
module dpq_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         line_valid = 1'b0;
  logic         line_ready;
  logic [255:0] line_data = '0;
  logic [31:0]  fetch_addr;
  logic         pred_valid = 1'b0;
  logic [31:0]  pred_target = '0;
  logic         res_valid = 1'b0;
  logic         res_mispredict = 1'b0;
  logic         dec_valid;
  logic         dec_ready = 1'b0;
  logic [4:0]   dec_count;
  logic [127:0] dec_data;
  logic         flush;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  dpq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .line_valid(line_valid), .line_ready(line_ready), .line_data(line_data),
    .fetch_addr(fetch_addr),
    .pred_valid(pred_valid), .pred_target(pred_target),
    .res_valid(res_valid), .res_mispredict(res_mispredict),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_count(dec_count), .dec_data(dec_data),
    .flush(flush)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic push_line(input logic [31:0] a);
    check("R2 fetch_addr before line", fetch_addr, a);
    check("R3 line_ready before line", 32'(line_ready), 1);
    for (int i = 0; i < 32; i++) line_data[8*i +: 8] = pat(a + 32'(i));
    line_valid = 1'b1;
    step();
    line_valid = 1'b0;
  endtask

  task automatic consume();
    dec_ready = 1'b1;
    step();
    dec_ready = 1'b0;
  endtask

  task automatic pulse_pred(input logic [31:0] t);
    pred_valid = 1'b1;
    pred_target = t;
    step();
    pred_valid = 1'b0;
  endtask

  task automatic pulse_res(input logic m);
    res_valid = 1'b1;
    res_mispredict = m;
    step();
    res_valid = 1'b0;
    res_mispredict = 1'b0;
  endtask

  task automatic expect_window(input string req, input logic [31:0] a);
    check({req, " dec_valid"}, 32'(dec_valid), 1);
    check({req, " dec_count"}, 32'(dec_count), 16);
    check({req, " byte0"}, 32'(dec_data[7:0]), 32'(pat(a)));
    check({req, " byte15"}, 32'(dec_data[127:120]), 32'(pat(a + 32'd15)));
  endtask

  // Entered on the cycle after a mispredict edge; leaves once recovery is over.
  task automatic recover_check();
    check("R7 flush pulse", 32'(flush), 1);
    check("R8 dec_valid low 1", 32'(dec_valid), 0);
    check("R8 line_ready low 1", 32'(line_ready), 0);
    step();
    check("R7 flush single cycle", 32'(flush), 0);
    check("R8 dec_valid low 2", 32'(dec_valid), 0);
    check("R8 line_ready low 2", 32'(line_ready), 0);
    step();
    check("R8 dec_valid low 3", 32'(dec_valid), 0);
    check("R8 line_ready low 3", 32'(line_ready), 0);
    step();
  endtask

  task automatic t_reset();
    check("R1 dec_valid", 32'(dec_valid), 0);
    check("R1 line_ready", 32'(line_ready), 1);
    check("R1 flush", 32'(flush), 0);
    check("R1 fetch_addr", fetch_addr, 32'h1000);
  endtask

  task automatic t_fill();
    push_line(32'h1000);
    push_line(32'h1020);
    check("R2 fetch_addr advanced", fetch_addr, 32'h1040);
    check("R3 full blocks line", 32'(line_ready), 0);
    expect_window("R4 first window", 32'h1000);
    consume();
    expect_window("R4 second window", 32'h1010);
    check("R3 16 free still blocks", 32'(line_ready), 0);
    consume();
    check("R3 32 free accepts", 32'(line_ready), 1);
    consume();
    consume();
    check("R4 drained", 32'(dec_valid), 0);
  endtask

  task automatic t_mispredict();
    push_line(32'h1040);
    consume();
    pulse_pred(32'h2000);
    check("R5 target address", fetch_addr, 32'h2000);
    check("R5 new buffer empty", 32'(dec_valid), 0);
    push_line(32'h2000);
    expect_window("R5 target bytes", 32'h2000);
    pulse_res(1'b1);
    check("R7 fetch_addr restored", fetch_addr, 32'h1060);
    recover_check();
    expect_window("R8 fall-through resumes", 32'h1050);
    consume();
    check("R7 target path dropped", 32'(dec_valid), 0);
  endtask

  task automatic t_correct();
    push_line(32'h1060);
    pulse_pred(32'h3000);
    push_line(32'h3000);
    pulse_res(1'b0);
    check("R6 no flush", 32'(flush), 0);
    check("R6 fetch continues", fetch_addr, 32'h3020);
    expect_window("R6 target stays active", 32'h3000);
    pulse_pred(32'h4000);
    check("R5 second switch address", fetch_addr, 32'h4000);
    check("R6 parked buffer was emptied", 32'(dec_valid), 0);
    pulse_res(1'b1);
    check("R7 restore after correct", fetch_addr, 32'h3020);
    recover_check();
    expect_window("R8 resumes target path", 32'h3000);
  endtask

  task automatic t_hold();
    pulse_pred(32'h5000);
    pulse_pred(32'h6000);
    check("R9 held branch stalls fetch", 32'(line_ready), 0);
    check("R9 fetch not yet moved", fetch_addr, 32'h5000);
    pulse_res(1'b0);
    check("R9 switch to held target", fetch_addr, 32'h6000);
    check("R9 fetch released", 32'(line_ready), 1);
    check("R9 freed buffer empty", 32'(dec_valid), 0);
    push_line(32'h6000);
    expect_window("R9 held target bytes", 32'h6000);
    pulse_res(1'b1);
    check("R9 back to first target", fetch_addr, 32'h5000);
    recover_check();
    check("R9 first target buffer empty", 32'(dec_valid), 0);
    pulse_pred(32'h7000);
    pulse_pred(32'h8000);
    pulse_res(1'b1);
    recover_check();
    check("R9 held target dropped", fetch_addr, 32'h5000);
    check("R9 fetch open after drop", 32'(line_ready), 1);
    push_line(32'h5000);
    expect_window("R9 fall-through refill", 32'h5000);
    consume();
    consume();
  endtask

  task automatic t_ignore();
    pulse_res(1'b1);
    check("R10 idle resolve no flush", 32'(flush), 0);
    check("R10 idle resolve keeps address", fetch_addr, 32'h5020);
    check("R10 idle resolve keeps ready", 32'(line_ready), 1);
    pulse_pred(32'h9000);
    pulse_res(1'b1);
    pred_valid = 1'b1;
    pred_target = 32'hA000;
    step();
    pred_valid = 1'b0;
    step();
    step();
    check("R10 prediction in recovery ignored", fetch_addr, 32'h5020);
    check("R10 ready after recovery", 32'(line_ready), 1);
    check("R10 still on fall-through buffer", 32'(dec_valid), 0);
  endtask

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_fill();
    t_mispredict();
    t_correct();
    t_hold();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule